// File: doc/BRIEF.md
# H-Bridge Leg Controller with Latched Fault Handling

This block is the digital core of a full-bridge DC motor driver. Two direction inputs select one of four bridge states. A PWM input chops the low-side switches for speed control. Each leg also has an enable line that works both ways. Outside logic can hold the line low to float the leg. The controller pulls the line low itself to report a fault. The block produces four gate-enable outputs: a high-side and a low-side switch for leg A and for leg B.

A fault on a leg switches that leg off and holds it off. The fault is either a high-side overtemperature flag or a low-side overcurrent flag. The held state ends only when that leg's direction input goes from low to high. A supply-window flag, for undervoltage or overvoltage, turns all switches off for as long as it is raised. When the decoded direction pattern changes, the bridge stays fully off for a programmable dead period before the new pattern is applied. The block also drives an enable for the current-sense output and a standby indication. Every asynchronous input passes through a two-flop synchroniser.

Top module: `hbridge_leg_ctrl`

## Requirements
- R1: Direction decode, with 1 meaning the input is high. dir_a=1,dir_b=0 turns on hs_a and ls_b. dir_a=0,dir_b=1 turns on ls_a and hs_b. Both high turns on both high sides. Both low turns on both low sides.
- R2: While pwm_i is low, ls_a_o and ls_b_o are off. The high-side outputs keep their decoded value. When pwm_i returns high, the low sides follow the decode again.
- R3: When en_a_i or en_b_i reads low, both gate outputs of that leg are off.
- R4: A raised hs_ot or ls_oc flag on a leg latches that leg off and sets its pull output. A pull output of 1 means the controller drives that enable line low. The other leg is not affected.
- R5: A latched leg stays off after its fault flag drops. Only a low-to-high transition of that leg's own direction input releases it. A transition on the other leg's direction input does not release it.
- R6: When the synchronised direction pair differs from the applied pattern, all four gates are off. The new pattern is applied only after it has held stable for DEL_CYC cycles.
- R7: While uv_i or ov_i is high, all four gates are off. Normal decoding resumes once both flags are low.
- R8: sense_en_o is high exactly when sense_dis_i (synchronised) is low.
- R9: standby_o is high only when both direction inputs, pwm_i and both enable lines are low and no leg fault is latched.
- R10: The high-side and low-side outputs of the same leg are never both on in one cycle. When a switch must change from one side to the other, the leg passes through one cycle with both sides off.
- R11: During reset all gate outputs, both pull outputs, standby_o and sense_en_o are 0, and both fault latches are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dir_a_i | input | 1 | Direction input, leg A (asynchronous) |
| dir_b_i | input | 1 | Direction input, leg B (asynchronous) |
| pwm_i | input | 1 | Low-side chopping input (asynchronous) |
| en_a_i | input | 1 | Level read back from leg A enable line |
| en_b_i | input | 1 | Level read back from leg B enable line |
| hs_ot_a_i | input | 1 | Leg A high-side overtemperature flag |
| ls_oc_a_i | input | 1 | Leg A low-side overcurrent flag |
| hs_ot_b_i | input | 1 | Leg B high-side overtemperature flag |
| ls_oc_b_i | input | 1 | Leg B low-side overcurrent flag |
| uv_i | input | 1 | Supply undervoltage flag |
| ov_i | input | 1 | Supply overvoltage flag |
| sense_dis_i | input | 1 | Current-sense disable request |
| hs_a_o | output | 1 | Leg A high-side gate enable |
| ls_a_o | output | 1 | Leg A low-side gate enable |
| hs_b_o | output | 1 | Leg B high-side gate enable |
| ls_b_o | output | 1 | Leg B low-side gate enable |
| pull_a_o | output | 1 | Drive leg A enable line low (fault report) |
| pull_b_o | output | 1 | Drive leg B enable line low (fault report) |
| sense_en_o | output | 1 | Current-sense output enable |
| standby_o | output | 1 | Standby indication |

## Verification
The bench targets the fault latch after its flag has dropped. A latch that cleared on the flag falling, or on the other leg's direction edge, would turn the faulted leg back on and release its enable line too early. The bench samples inside the mode-change dead window. A design without the window would show the new switch pattern at once; one that skipped it on direction reversal would do the same. PWM low is checked with a high side that must stay on, which catches a design that also chops the high sides. Standby is checked with a fault latched, then after the latch is cleared. A monitor watches every cycle for both switches of one leg being on together.

// File: rtl/hb_ctrl_pkg.sv
package hb_ctrl_pkg;
  typedef struct packed {
    logic hs;
    logic ls;
  } leg_gate_t;

  // Per-leg decode: a high direction input selects the high side, a low one
  // selects the low side, and the low side is chopped by PWM.
  function automatic leg_gate_t leg_decode(input logic dir, input logic pwm);
    leg_gate_t g;
    g.hs = dir;
    g.ls = ~dir & pwm;
    return g;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic dir_i,
  output logic latched_o
);
  logic dir_prev;
  logic clr_rise;

  assign clr_rise = dir_i & ~dir_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_prev  <= 1'b0;
      latched_o <= 1'b0;
    end else begin
      dir_prev <= dir_i;
      if (fault_i)       latched_o <= 1'b1;
      else if (clr_rise) latched_o <= 1'b0;
    end
  end

  // R4: a raised flag is held on the next cycle
  p_fault_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> latched_o);

  // R5: release happens only after a rising direction edge
  p_release_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched_o) |-> $past(clr_rise));
endmodule

// File: rtl/hb_mode_gate.sv
module hb_mode_gate #(
  parameter int DEL_CYC = 40000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  output logic [1:0] mode_o,
  output logic       pending_o
);
  localparam int CW = $clog2(DEL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEL_CYC - 1);

  logic [1:0]    mode_d;
  logic [CW-1:0] cnt;

  assign pending_o = (mode_i != mode_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= 2'b00;
      mode_d <= 2'b00;
      cnt    <= '0;
    end else begin
      mode_d <= mode_i;
      if (!pending_o || (mode_i != mode_d)) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        mode_o <= mode_i;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: the applied pattern only ever moves to the requested one
  p_mode_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> (mode_o == $past(mode_i)));
endmodule

// File: rtl/hb_gate_out.sv
module hb_gate_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_hs,
  input  logic tgt_ls,
  output logic hs_o,
  output logic ls_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
    end else begin
      hs_o <= tgt_hs & ~ls_o;
      ls_o <= tgt_ls & ~hs_o;
    end
  end

  // R10: one leg never conducts through both switches
  p_leg_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_o && ls_o));

  // R10: a side change passes through an all-off cycle
  p_break_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> !$past(ls_o));
endmodule

// File: rtl/hbridge_leg_ctrl.sv
module hbridge_leg_ctrl #(
  parameter int DEL_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a_i,
  input  logic dir_b_i,
  input  logic pwm_i,
  input  logic en_a_i,
  input  logic en_b_i,
  input  logic hs_ot_a_i,
  input  logic ls_oc_a_i,
  input  logic hs_ot_b_i,
  input  logic ls_oc_b_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic sense_dis_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o,
  output logic pull_a_o,
  output logic pull_b_o,
  output logic sense_en_o,
  output logic standby_o
);
  import hb_ctrl_pkg::*;

  localparam int NLEG = 2;
  localparam int NSYN = 12;

  logic [NSYN-1:0] raw_in, syn;
  logic [NLEG-1:0] s_dir, s_en, s_flt, latched, hs, ls;
  logic            s_pwm, s_uv, s_ov, s_sdis, supply_bad, pending;
  logic [1:0]      mode_applied;

  assign raw_in = {sense_dis_i, ov_i, uv_i, pwm_i,
                   ls_oc_b_i, hs_ot_b_i, ls_oc_a_i, hs_ot_a_i,
                   en_b_i, en_a_i, dir_b_i, dir_a_i};

  hb_sync #(.W(NSYN)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

  assign s_dir      = syn[1:0];
  assign s_en       = syn[3:2];
  assign s_flt      = {syn[7] | syn[6], syn[5] | syn[4]};
  assign s_pwm      = syn[8];
  assign s_uv       = syn[9];
  assign s_ov       = syn[10];
  assign s_sdis     = syn[11];
  assign supply_bad = s_uv | s_ov;

  hb_mode_gate #(.DEL_CYC(DEL_CYC)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_i(s_dir),
    .mode_o(mode_applied), .pending_o(pending)
  );

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    leg_gate_t dec;
    logic      allow;

    hb_fault_latch u_flt (
      .clk(clk), .rst_n(rst_n), .fault_i(s_flt[i]),
      .dir_i(s_dir[i]), .latched_o(latched[i])
    );

    assign dec   = leg_decode(mode_applied[i], s_pwm);
    assign allow = s_en[i] & ~latched[i] & ~supply_bad & ~pending;

    hb_gate_out u_out (
      .clk(clk), .rst_n(rst_n),
      .tgt_hs(dec.hs & allow), .tgt_ls(dec.ls & allow),
      .hs_o(hs[i]), .ls_o(ls[i])
    );

    // R3: an externally lowered enable floats the leg
    p_en_low_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !s_en[i] |=> (!hs[i] && !ls[i]));
  end

  assign hs_a_o   = hs[0];
  assign ls_a_o   = ls[0];
  assign hs_b_o   = hs[1];
  assign ls_b_o   = ls[1];
  assign pull_a_o = latched[0];
  assign pull_b_o = latched[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_en_o <= 1'b0;
      standby_o  <= 1'b0;
    end else begin
      sense_en_o <= ~s_sdis;
      standby_o  <= ~(|s_dir) & ~s_pwm & ~(|s_en) & ~(|latched);
    end
  end

  // R2: PWM low removes both low sides
  p_pwm_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s_pwm |=> (!ls_a_o && !ls_b_o));

  // R7: supply outside window turns the bridge off
  p_supply_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

  // R6: nothing conducts while a pattern change is pending
  p_wait_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

  // R8: sense enable follows the inverted disable
  p_sense_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_sdis |=> !sense_en_o);

  // R9: no standby while a fault is held
  p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|latched) |=> !standby_o);
endmodule

// File: tb/hbridge_leg_ctrl_test.sv
module hbridge_leg_ctrl_test;
  localparam int DEL = 24;
  localparam int SETTLE = DEL + 12;
  localparam int NV = 9;

  // row: dir_a dir_b pwm en_a en_b | hs_a ls_a hs_b ls_b
  localparam logic [8:0] VEC [NV] = '{
    9'b10111_1001, 9'b01111_0110, 9'b11111_1010,
    9'b00111_0101, 9'b10011_1000, 9'b00011_0000,
    9'b01101_0010, 9'b10110_1000, 9'b00100_0000
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_a = 0, dir_b = 0, pwm = 0, en_a = 0, en_b = 0;
  logic ot_a = 0, oc_a = 0, ot_b = 0, oc_b = 0, uv = 0, ov = 0, sdis = 0;
  logic hs_a, ls_a, hs_b, ls_b, pull_a, pull_b, sense_en, standby;
  int n_chk = 0, n_bad = 0, bbm_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  hbridge_leg_ctrl #(.DEL_CYC(DEL)) uut (
    .clk(clk), .rst_n(rst_n), .dir_a_i(dir_a), .dir_b_i(dir_b), .pwm_i(pwm),
    .en_a_i(en_a), .en_b_i(en_b), .hs_ot_a_i(ot_a), .ls_oc_a_i(oc_a),
    .hs_ot_b_i(ot_b), .ls_oc_b_i(oc_b), .uv_i(uv), .ov_i(ov),
    .sense_dis_i(sdis), .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b),
    .ls_b_o(ls_b), .pull_a_o(pull_a), .pull_b_o(pull_b),
    .sense_en_o(sense_en), .standby_o(standby)
  );

  always @(negedge clk)
    if (rst_n && ((hs_a && ls_a) || (hs_b && ls_b))) bbm_bad++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gates();
    return {4'b0, hs_a, ls_a, hs_b, ls_b};
  endfunction

  task automatic drive(input logic da, input logic db, input logic p,
                       input logic ea, input logic eb);
    dir_a = da; dir_b = db; pwm = p; en_a = ea; en_b = eb;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    step(3);
    // R11: reset state
    check("R11 reset", {gates(), pull_a, pull_b, sense_en, standby}, 8'h00);
    rst_n = 1'b1;
    step(6);
    check("R9 standby all low", {7'b0, standby}, 8'h01);
    check("R8 sense enabled", {7'b0, sense_en}, 8'h01);

    // R1 R2 R3: table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      step(SETTLE);
      check($sformatf("R1 R2 R3 vector %0d", i), gates(), {4'b0, VEC[i][3:0]});
    end

    // R4 R5: fault on leg A
    drive(1, 0, 1, 1, 1);
    step(SETTLE);
    check("R1 clockwise", gates(), 8'h09);
    ot_a = 1; step(3); ot_a = 0; step(6);
    check("R4 leg A off", gates(), 8'h01);
    check("R4 pulls", {6'b0, pull_a, pull_b}, 8'h02);
    step(20);
    check("R5 held after flag drop", {gates()[3:0], pull_a, 3'b0}, 8'h18);
    dir_b = 1; step(SETTLE);
    check("R5 other leg rise no clear", {gates()[3:0], pull_a, 3'b0}, 8'h28);
    dir_a = 0; step(4); dir_a = 1; step(SETTLE);
    check("R5 own rise clears", {gates()[3:0], pull_a, 3'b0}, 8'hA0);

    // R9: fault on B blocks standby
    oc_b = 1; step(3); oc_b = 0; step(6);
    check("R4 leg B off", {gates()[3:0], pull_a, pull_b, 2'b0}, 8'h84);
    drive(0, 0, 0, 0, 0); step(SETTLE);
    check("R9 no standby with fault", {7'b0, standby}, 8'h00);
    dir_b = 1; step(4); dir_b = 0; step(SETTLE);
    check("R9 standby after clear", {6'b0, pull_b, standby}, 8'h01);

    // R7: supply window
    drive(1, 0, 1, 1, 1); step(SETTLE);
    uv = 1; step(5);
    check("R7 undervoltage off", gates(), 8'h00);
    uv = 0; step(6);
    check("R7 resume after uv", gates(), 8'h09);
    ov = 1; step(5);
    check("R7 overvoltage off", gates(), 8'h00);
    ov = 0; step(6);
    check("R7 resume after ov", gates(), 8'h09);

    // R6: dead window on reversal
    drive(0, 1, 1, 1, 1); step(DEL / 2);
    check("R6 off inside window", gates(), 8'h00);
    step(DEL);
    check("R6 applied after window", gates(), 8'h06);

    // R2: PWM low keeps high side
    pwm = 0; step(5);
    check("R2 pwm low", gates(), 8'h02);
    pwm = 1; step(5);
    check("R2 pwm high", gates(), 8'h06);

    // R8: sense disable
    sdis = 1; step(5);
    check("R8 sense disabled", {7'b0, sense_en}, 8'h00);
    sdis = 0; step(5);
    check("R8 sense re-enabled", {7'b0, sense_en}, 8'h01);

    // R10: both sides of a leg never on together
    check("R10 leg exclusion", 8'(bbm_bad), 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule